// File: doc/BRIEF.md
# Serial Port Register Front End with Programmable Baud Timing

This block is the register file and bit-rate timing stage at the front of a 16550-compatible serial port. A host reaches it through a byte-wide register port (address, write enable, read enable, write data, read data). It keeps a scratch byte, an interrupt-enable byte, a line-control byte and a 16-bit baud divisor that is stored as two byte latches. The divisor latches share their addresses with the data and interrupt-enable registers. The divisor-access flag in the line-control byte selects which pair is reached.

The timing stage divides the system clock by a fixed 4 and then by the programmed divisor. This yields a 16x oversampling strobe, so the serial rate equals the system clock divided by 64 times the divisor. A second strobe marks every sixteenth oversampling strobe as a bit boundary. At 33.33 MHz, divisors 0x36, 0x1B, 0x12, 0x0D and 0x09 give roughly 9600, 19200, 28800, 38400 and 57600 bit/s. The interrupt-enable bits leave the block only as level signals. Shifting, FIFOs and interrupt identification are handled elsewhere.

Top module: `uart_baud_front`

## Requirements
- R1: After reset, every address reads 0x00, the divisor is zero and neither strobe is asserted.
- R2: Address 7 is a scratch byte that reads back what was written. Writing it changes no strobe and no enable output.
- R3: The divisor-access flag is physical bit 7 of the line-control byte at address 3. While it is set, address 0 reaches the divisor low byte and address 1 reaches the divisor high byte, and both read back as written.
- R4: While the access flag is clear, address 1 is the interrupt-enable byte. Address 0 is the data register, which reads 0x00 here and ignores writes. No write alters the divisor in this state.
- R5: The enable outputs follow interrupt-enable byte bits: bit 0 drives received-data-available, bit 1 drives transmit-holding-empty, and bit 2 drives receiver line status.
- R6: With a nonzero divisor D, the 16x strobe is a one-cycle pulse that repeats every 4*D system clocks.
- R7: The bit strobe is asserted only together with a 16x strobe, once every 16 of them, so its period is 64*D clocks.
- R8: While the divisor is zero, neither strobe is ever asserted.
- R9: A write to either divisor byte restarts the timing chain. The first 16x strobe then falls in the (4*D)-th cycle after the write edge.
- R10: Addresses 2, 4, 5 and 6 read 0x00 and ignore writes. read data is 0x00 while read enable is low, and a read changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_rd | input | 1 | Read enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational while reg_rd is high |
| tick_16x | output | 1 | Oversampling strobe |
| tick_bit | output | 1 | Bit-boundary strobe |
| en_rx_data | output | 1 | Received-data-available interrupt enable |
| en_tx_empty | output | 1 | Transmit-holding-empty interrupt enable |
| en_line_stat | output | 1 | Receiver line-status interrupt enable |

## Verification
Several rules hold on every cycle and are checked that way. The bit strobe never appears without the 16x strobe. Both strobes stay low while the divisor is zero and in the cycle after a divisor write. Each counter stays below its modulus. A read never disturbs the register contents, and the divisor cannot move while the access flag is clear. Other properties can only be shown by the directed scenarios: the exact strobe periods for each table divisor, the latency from a divisor write to the first strobe, the address aliasing under the access flag, and readback of every register.

// File: rtl/uart_bf_pkg.sv
package uart_bf_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int DIV_W      = 16;
  localparam int PRESCALE   = 4;
  localparam int OVERSAMPLE = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA_DLO = 3'd0,
    A_IER_DHI  = 3'd1,
    A_LCR      = 3'd3,
    A_SCRATCH  = 3'd7
  } reg_addr_e;

  // Bits are specified counting from the most significant end.
  function automatic int msb0(input int idx);
    return DATA_W - 1 - idx;
  endfunction

  localparam int LCR_ACCESS_BIT = msb0(0);
  localparam int IER_LSTAT_BIT  = msb0(5);
  localparam int IER_TXE_BIT    = msb0(6);
  localparam int IER_RXD_BIT    = msb0(7);

  // System clocks between oversampling strobes for a given divisor.
  function automatic int unsigned clocks_per_tick(input int unsigned div);
    return PRESCALE * div;
  endfunction
endpackage

// File: rtl/uart_bf_modcnt.sv
module uart_bf_modcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt;
  logic         idle;
  logic         at_last;

  assign idle    = (limit == '0);
  assign at_last = (cnt == limit - W'(1));
  assign wrap    = step & at_last & ~idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || idle)  cnt <= '0;
    else if (step)         cnt <= at_last ? '0 : cnt + W'(1);
  end

  // R6: counter never leaves its modulus range
  p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (cnt < limit));

  // R8: a zero modulus keeps the counter parked at zero
  p_idle_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cnt == '0));
endmodule

// File: rtl/uart_bf_regs.sv
module uart_bf_regs
  import uart_bf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DIV_W-1:0]  divisor,
  output logic              div_wr,
  output logic [DATA_W-1:0] ier_q
);
  logic [DATA_W-1:0] lcr_q, scr_q, dlo_q, dhi_q;
  logic              access;
  logic              wr_dlo, wr_dhi, wr_ier, wr_lcr, wr_scr;
  logic [DATA_W-1:0] rd_mux;

  assign access  = lcr_q[LCR_ACCESS_BIT];
  assign wr_dlo  = reg_wr &  access & (reg_addr == A_DATA_DLO);
  assign wr_dhi  = reg_wr &  access & (reg_addr == A_IER_DHI);
  assign wr_ier  = reg_wr & ~access & (reg_addr == A_IER_DHI);
  assign wr_lcr  = reg_wr & (reg_addr == A_LCR);
  assign wr_scr  = reg_wr & (reg_addr == A_SCRATCH);
  assign div_wr  = wr_dlo | wr_dhi;
  assign divisor = {dhi_q, dlo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0;
      scr_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
      ier_q <= '0;
    end else begin
      if (wr_lcr) lcr_q <= reg_wdata;
      if (wr_scr) scr_q <= reg_wdata;
      if (wr_dlo) dlo_q <= reg_wdata;
      if (wr_dhi) dhi_q <= reg_wdata;
      if (wr_ier) ier_q <= reg_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_DATA_DLO: rd_mux = access ? dlo_q : '0;
      A_IER_DHI:  rd_mux = access ? dhi_q : ier_q;
      A_LCR:      rd_mux = lcr_q;
      A_SCRATCH:  rd_mux = scr_q;
      default:    rd_mux = '0;
    endcase
  end

  assign reg_rdata = reg_rd ? rd_mux : '0;

  // R10: reads leave every register untouched
  p_read_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> $stable({lcr_q, scr_q, dlo_q, dhi_q, ier_q}));

  // R2: scratch byte only moves on its own write
  p_scratch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_SCRATCH) |=> $stable(scr_q));

  // R4: divisor frozen while the access flag is clear
  p_div_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> $stable({dhi_q, dlo_q}));
endmodule

// File: rtl/uart_baud_front.sv
module uart_baud_front
  import uart_bf_pkg::*;
#(
  parameter int PRE_DIV  = PRESCALE,
  parameter int OS_RATIO = OVERSAMPLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_16x,
  output logic              tick_bit,
  output logic              en_rx_data,
  output logic              en_tx_empty,
  output logic              en_line_stat
);
  localparam int PW = $clog2(PRE_DIV) + 1;
  localparam int OW = $clog2(OS_RATIO) + 1;

  logic [DIV_W-1:0]  divisor;
  logic              div_wr;
  logic              div_zero;
  logic              pre_tick;
  logic              chain_clr;
  logic [DATA_W-1:0] ier_q;

  uart_bf_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .divisor   (divisor),
    .div_wr    (div_wr),
    .ier_q     (ier_q)
  );

  assign div_zero  = (divisor == '0);
  assign chain_clr = div_wr | div_zero;

  uart_bf_modcnt #(.W(PW)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (chain_clr),
    .step  (1'b1),
    .limit (PW'(PRE_DIV)),
    .wrap  (pre_tick)
  );

  uart_bf_modcnt #(.W(DIV_W)) u_divide (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (div_wr),
    .step  (pre_tick),
    .limit (divisor),
    .wrap  (tick_16x)
  );

  uart_bf_modcnt #(.W(OW)) u_oversample (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (chain_clr),
    .step  (tick_16x),
    .limit (OW'(OS_RATIO)),
    .wrap  (tick_bit)
  );

  assign en_rx_data   = ier_q[IER_RXD_BIT];
  assign en_tx_empty  = ier_q[IER_TXE_BIT];
  assign en_line_stat = ier_q[IER_LSTAT_BIT];

  // R7: bit strobe only coincides with an oversampling strobe
  p_bit_with_16x_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_bit |-> tick_16x);

  // R8: no strobes while the divisor is zero
  p_zero_div_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (!tick_16x && !tick_bit));

  // R9: chain restarts from a clean phase after a divisor write
  p_reload_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (!pre_tick && !tick_16x));

  // R6: oversampling strobes are single-cycle pulses
  p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_16x |=> !tick_16x);
endmodule

// File: tb/test_uart_baud_front.sv
module test_uart_baud_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_16x, tick_bit, en_rx_data, en_tx_empty, en_line_stat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_baud_front i_uart_baud_front (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_16x(tick_16x), .tick_bit(tick_bit), .en_rx_data(en_rx_data),
    .en_tx_empty(en_tx_empty), .en_line_stat(en_line_stat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string req);
    logic [7:0] d;
    rd(a, d);
    check(d == e, req, d, e);
  endtask

  task automatic quiet_cycles(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick_16x || tick_bit) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) expect_rd(3'(a), 8'h00, "R1 reset readback");
    check({en_rx_data, en_tx_empty, en_line_stat} == 3'b000, "R1 enables",
          {en_rx_data, en_tx_empty, en_line_stat}, 0);
    quiet_cycles(50, "R1 no strobes after reset");
  endtask

  task automatic t_scratch;
    wr(3'd7, 8'hA5);
    expect_rd(3'd7, 8'hA5, "R2 scratch readback");
    wr(3'd7, 8'h5A);
    expect_rd(3'd7, 8'h5A, "R2 scratch rewrite");
    check({en_rx_data, en_tx_empty, en_line_stat} == 3'b000, "R2 enables untouched",
          {en_rx_data, en_tx_empty, en_line_stat}, 0);
    quiet_cycles(20, "R2 no strobes from scratch");
  endtask

  task automatic t_ier;
    wr(3'd3, 8'h03);
    wr(3'd1, 8'h01);
    check(en_rx_data && !en_tx_empty && !en_line_stat, "R5 bit0 rx data", en_rx_data, 1);
    wr(3'd1, 8'h02);
    check(!en_rx_data && en_tx_empty && !en_line_stat, "R5 bit1 tx empty", en_tx_empty, 1);
    wr(3'd1, 8'h04);
    check(!en_rx_data && !en_tx_empty && en_line_stat, "R5 bit2 line status", en_line_stat, 1);
    wr(3'd1, 8'h07);
    expect_rd(3'd1, 8'h07, "R4 IER readback");
    wr(3'd3, 8'h83);
    wr(3'd1, 8'h00);
    check({en_rx_data, en_tx_empty, en_line_stat} == 3'b111, "R3 high-byte write spares IER",
          {en_rx_data, en_tx_empty, en_line_stat}, 7);
    wr(3'd3, 8'h03);
    expect_rd(3'd3, 8'h03, "R3 LCR readback");
  endtask

  task automatic t_access;
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h36);
    wr(3'd1, 8'h12);
    expect_rd(3'd0, 8'h36, "R3 divisor low readback");
    expect_rd(3'd1, 8'h12, "R3 divisor high readback");
    wr(3'd3, 8'h00);
    expect_rd(3'd0, 8'h00, "R4 data address reads zero");
    expect_rd(3'd1, 8'h07, "R4 address 1 is IER");
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h07);
    wr(3'd3, 8'h80);
    expect_rd(3'd0, 8'h36, "R4 divisor low kept");
    expect_rd(3'd1, 8'h12, "R4 divisor high kept");
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    quiet_cycles(300, "R8 zero divisor idle");
  endtask

  task automatic t_unimpl;
    for (int a = 2; a < 7; a++) if (a != 3) wr(3'(a), 8'hC3);
    for (int a = 2; a < 7; a++) if (a != 3) expect_rd(3'(a), 8'h00, "R10 unimplemented reads zero");
    reg_addr = 3'd7; reg_rd = 1'b0;
    #1 check(reg_rdata == 8'h00, "R10 rdata zero without read", reg_rdata, 0);
    @(negedge clk);
    expect_rd(3'd7, 8'h5A, "R10 scratch unchanged by reads");
  endtask

  task automatic t_rate(input int d);
    int n, n16;
    wr(3'd3, 8'h80);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'(d));
    n = 0;
    while (!tick_16x) begin @(negedge clk); n++; end
    check(n == 4 * d - 1, "R9 first strobe latency", n + 1, 4 * d);
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!tick_16x);
      check(n == 4 * d, "R6 16x period", n, 4 * d);
    end
    while (!tick_bit) @(negedge clk);
    n = 0; n16 = 0;
    do begin
      @(negedge clk); n++;
      if (tick_16x) n16++;
    end while (!tick_bit);
    check(n == 64 * d, "R7 bit period", n, 64 * d);
    check(n16 == 16, "R7 16x strobes per bit", n16, 16);
  endtask

  task automatic t_zero;
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    quiet_cycles(500, "R8 strobes stop at zero divisor");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scratch();
    t_ier();
    t_access();
    t_unimpl();
    t_rate(8'h36);
    t_rate(8'h1B);
    t_rate(8'h12);
    t_rate(8'h0D);
    t_rate(8'h09);
    t_rate(1);
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule